// File: doc/BRIEF.md
# 64-bit Parallel CRC Signature Unit

This block keeps a running 64-bit CRC signature over a stream of 64-bit data words. The generator is x^64 + x^4 + x^3 + x + 1 (constant 0x1B with the top term implied). The seed is zero. Neither data nor result is bit-reflected, and no final XOR is applied. A whole word is absorbed in one clock through an unrolled network of 64 single-bit shift steps.

The host drives a narrow 32-bit port. The half of a word written to address 0 is held in a latch. A write to address 1 supplies the other half, forms the full word and launches one update. The signature is read back as two 32-bit halves. A parameter decides which half each address stands for. With swapping on, the address-0 half is the upper half of both the word and the signature, so the host can match a calculation done on a little-endian machine that swaps 32-bit words but not bytes. A message whose length is not a whole number of words is padded with zero bytes by the host before it is written. A synchronous clear input returns the signature to the zero seed.

Top module: `crc64_sig_unit`

## Requirements
- R1: After reset both read addresses return 0, and the held half is 0. A first address-1 write with no address-0 write folds the word whose held half is zero.
- R2: A write to address 0 does not change the signature. Both read addresses return the same values before and after it.
- R3: An address-1 write sampled at clock edge n leaves the signature unchanged after edge n. The new signature is visible after edge n+1.
- R4: Each folded word updates the signature by 64 bit steps, using word bit 63 first and bit 0 last. In each step fb = sig[63] XOR d, the signature shifts left by one, and if fb is 1 it is XORed with 0x1B.
- R5: Starting from a zero signature with swapping off, writing 0x05060708 to address 0 and then 0x01020304 to address 1 gives a signature of 0x1B362D6C775A41D8. Address 0 then reads 0x775A41D8 and address 1 reads 0x1B362D6C.
- R6: Clear high at an edge sets the signature to 0. If a word update reaches the signature at the same edge, clear wins and the word is discarded.
- R7: With swapping off (SWAP_HALVES=0), the word is {address-1 data, held half}. Reading address 0 returns signature bits [31:0] and address 1 returns bits [63:32]. The read is combinational.
- R8: With SWAP_HALVES=1, the word is {held half, address-1 data}. Reading address 0 returns signature bits [63:32] and address 1 returns bits [31:0].
- R9: The held half keeps the most recent address-0 write. It stays unchanged through address-1 writes and clears, so later address-1 writes reuse it.
- R10: Every address-1 write folds exactly one word. Address-1 writes on consecutive cycles fold consecutive words in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the signature to the seed |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write address: 0 holds a half, 1 completes the word and launches the update |
| wr_data | input | 32 | Write data half |
| rd_addr | input | 1 | Read address selecting a signature half |
| rd_data | output | 32 | Selected signature half |

## Verification
A clear and a word update can reach the signature register at the same clock edge. The bench provokes this by raising clear in the cycle right after an address-1 write, when the assembled word is on its way to the register. This is done with a nonzero signature already in place and with a nonzero word, so a wrong priority would show. The collision is judged by reading both halves afterwards and expecting zero. The bench also feeds rare random clears against a dense random write stream, and compares both the native and the swapped instance with a bit-serial model every cycle.

// File: rtl/crc64_pkg.sv
// Package: shared defaults and types for the 64-bit CRC signature unit.
// Assumes the signature width is even so it splits into two host halves.
package crc64_pkg;
    localparam int unsigned SIG_W_DEF  = 64;
    localparam int unsigned HALF_W_DEF = SIG_W_DEF / 2;
    localparam logic [SIG_W_DEF-1:0] GEN_POLY_DEF = 64'h0000_0000_0000_001B;

    typedef logic [SIG_W_DEF-1:0]  sig_word_t;
    typedef logic [HALF_W_DEF-1:0] host_half_t;

    // Role of a host address within the narrow port
    typedef enum logic {
        ADDR_HOLD   = 1'b0,
        ADDR_LAUNCH = 1'b1
    } host_addr_e;
endpackage

// File: rtl/crc64_word_asm.sv
// Word assembly: keeps the half written to the holding address. A write to
// the launch address forms the full word from the held half and the new data,
// registers it, and raises the update strobe for one cycle.
// SWAP_HALVES picks whether the held half is the low (0) or high (1) half.
// Assumes at most one write per cycle. The held half survives clears.
module crc64_word_asm
    import crc64_pkg::*;
#(
    parameter int unsigned HALF_W      = HALF_W_DEF,
    parameter bit          SWAP_HALVES = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [HALF_W-1:0]   wr_data,
    output logic [2*HALF_W-1:0] word_q,
    output logic                word_vld
);
    localparam int unsigned WORD_W = 2 * HALF_W;

    logic [HALF_W-1:0] hold_q;
    logic [WORD_W-1:0] word_d;
    logic              hold_we;
    logic              launch;

    assign hold_we = wr_en && (wr_addr == ADDR_HOLD);
    assign launch  = wr_en && (wr_addr == ADDR_LAUNCH);

    // Place the held half and the launching half according to the ordering
    generate
        if (SWAP_HALVES) begin : g_swapped
            assign word_d = {hold_q, wr_data};
        end else begin : g_native
            assign word_d = {wr_data, hold_q};
        end
    endgenerate

    // Capture the first-written half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hold_we) begin
            hold_q <= wr_data;
        end
    end

    // Register the assembled word and its one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= launch;
            if (launch) begin
                word_q <= word_d;
            end
        end
    end
endmodule

// File: rtl/crc64_fold_net.sv
// Fold network: purely combinational. Applies W serial LFSR steps to the
// signature, taking data bits from the top bit down to bit 0.
// Each step: fb = msb ^ data bit; shift left; XOR POLY if fb is set.
// Assumes the data word has the same width as the signature.
module crc64_fold_net
    import crc64_pkg::*;
#(
    parameter int unsigned      W    = SIG_W_DEF,
    parameter logic [W-1:0]     POLY = GEN_POLY_DEF
) (
    input  logic [W-1:0] sig_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] sig_out
);
    // One scope per bit step, chained from the top data bit down
    generate
        for (genvar k = 0; k < W; k++) begin : g_step
            localparam int unsigned DBIT = W - 1 - k;
            logic [W-1:0] s_in;
            logic [W-1:0] s_out;
            logic         fb;

            if (k == 0) begin : g_first
                assign s_in = sig_in;
            end else begin : g_next
                assign s_in = g_step[k-1].s_out;
            end

            assign fb    = s_in[W-1] ^ data_in[DBIT];
            assign s_out = {s_in[W-2:0], 1'b0} ^ (POLY & {W{fb}});
        end
    endgenerate

    assign sig_out = g_step[W-1].s_out;
endmodule

// File: rtl/crc64_sig_reg.sv
// Signature register: holds the running signature. Clear has priority over a
// word update that lands at the same edge. Reset and clear both load zero.
module crc64_sig_reg
    import crc64_pkg::*;
#(
    parameter int unsigned W = SIG_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] sig_nxt,
    output logic [W-1:0] sig_q
);
    // Load seed, next value or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (clr) begin
            sig_q <= '0;
        end else if (upd) begin
            sig_q <= sig_nxt;
        end
    end
endmodule

// File: rtl/crc64_readback.sv
// Read-back mux: returns one signature half for the host address.
// The ordering follows SWAP_HALVES, the same as the write side.
module crc64_readback
    import crc64_pkg::*;
#(
    parameter int unsigned HALF_W      = HALF_W_DEF,
    parameter bit          SWAP_HALVES = 1'b0
) (
    input  logic [2*HALF_W-1:0] sig,
    input  logic                rd_addr,
    output logic [HALF_W-1:0]   rd_data
);
    logic [HALF_W-1:0] lo_half;
    logic [HALF_W-1:0] hi_half;

    assign lo_half = sig[HALF_W-1:0];
    assign hi_half = sig[2*HALF_W-1:HALF_W];

    // Select the half named by the address
    generate
        if (SWAP_HALVES) begin : g_swapped
            assign rd_data = rd_addr ? lo_half : hi_half;
        end else begin : g_native
            assign rd_data = rd_addr ? hi_half : lo_half;
        end
    endgenerate
endmodule

// File: rtl/crc64_sig_unit.sv
// Top: 64-bit CRC signature unit with a 32-bit host port.
// Assembles words from two half writes, folds one word per cycle through the
// unrolled network, and keeps the signature readable in halves.
// Assumes CRC_W is even. Data is padded to whole words by the host.
module crc64_sig_unit
    import crc64_pkg::*;
#(
    parameter int unsigned          CRC_W       = SIG_W_DEF,
    parameter logic [CRC_W-1:0]     POLY        = GEN_POLY_DEF,
    parameter bit                   SWAP_HALVES = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [CRC_W/2-1:0]   wr_data,
    input  logic                 rd_addr,
    output logic [CRC_W/2-1:0]   rd_data
);
    localparam int unsigned HALF_W = CRC_W / 2;

    logic [CRC_W-1:0] word_q;
    logic             word_vld;
    logic [CRC_W-1:0] sig_q;
    logic [CRC_W-1:0] sig_nxt;

    crc64_word_asm #(
        .HALF_W      (HALF_W),
        .SWAP_HALVES (SWAP_HALVES)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .word_q   (word_q),
        .word_vld (word_vld)
    );

    crc64_fold_net #(
        .W    (CRC_W),
        .POLY (POLY)
    ) u_net (
        .sig_in  (sig_q),
        .data_in (word_q),
        .sig_out (sig_nxt)
    );

    crc64_sig_reg #(
        .W (CRC_W)
    ) u_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .upd     (word_vld),
        .sig_nxt (sig_nxt),
        .sig_q   (sig_q)
    );

    crc64_readback #(
        .HALF_W      (HALF_W),
        .SWAP_HALVES (SWAP_HALVES)
    ) u_rd (
        .sig     (sig_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/crc64_sig_unit_chk.sv
// Checker: temporal properties across the assembly stage and the signature
// register of crc64_sig_unit. Attached through bind below.
module crc64_sig_unit_chk #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         wr_en,
    input logic         wr_addr,
    input logic         upd,
    input logic [W-1:0] word,
    input logic [W-1:0] sig
);
    // R6: clear leaves a zero signature, whatever else happened
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sig == '0));

    // R2: with no strobe and no clear the signature holds
    p_sig_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> $stable(sig));

    // R10: an update strobe only follows a launch write
    p_strobe_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(wr_en && wr_addr));

    // R2: a hold write raises no strobe
    p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> !upd);

    // R4: a zero word folded into a zero signature keeps it zero
    p_zero_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && (sig == '0) && (word == '0)) |=> (sig == '0));
endmodule

bind crc64_sig_unit crc64_sig_unit_chk #(.W(CRC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .upd     (word_vld),
    .word    (word_q),
    .sig     (sig_q)
);

// File: tb/crc64_sig_unit_bench.sv
// Bench: a native and a swapped instance on one host bus, a bit-serial
// reference model updated each edge, per-cycle comparison and directed cases.
module crc64_sig_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    wire  [31:0] rd_n;
    wire  [31:0] rd_s;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    crc64_sig_unit #(.SWAP_HALVES(1'b0)) u_crc64_sig_unit (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_n)
    );

    crc64_sig_unit #(.SWAP_HALVES(1'b1)) u_crc64_sig_unit_swp (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_s)
    );

    // Bit-serial fold from the requirement R4
    function automatic logic [63:0] ref_fold(input logic [63:0] c, input logic [63:0] d);
        for (int i = 63; i >= 0; i--) begin
            logic fb;
            fb = c[63] ^ d[i];
            c  = {c[62:0], 1'b0};
            if (fb) c = c ^ 64'h1B;
        end
        return c;
    endfunction

    // Reference model state
    logic [31:0] m_hold;
    logic [63:0] m_word_n, m_word_s, m_sig_n, m_sig_s;
    logic        m_vld;

    // Model: one register step per edge, as R1, R3, R6, R7, R8, R9 describe
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold <= '0; m_vld <= 1'b0; m_word_n <= '0; m_word_s <= '0;
            m_sig_n <= '0; m_sig_s <= '0;
        end else begin
            if (clr) begin
                m_sig_n <= '0; m_sig_s <= '0;
            end else if (m_vld) begin
                m_sig_n <= ref_fold(m_sig_n, m_word_n);
                m_sig_s <= ref_fold(m_sig_s, m_word_s);
            end
            m_vld <= wr_en && wr_addr;
            if (wr_en && wr_addr) begin
                m_word_n <= {wr_data, m_hold};
                m_word_s <= {m_hold, wr_data};
            end
            if (wr_en && !wr_addr) m_hold <= wr_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of both instances with the model (R4, R7, R8)
    always begin
        @(negedge clk);
        #5;
        if (rst_n && !done) begin
            chk("R4 R7 native", rd_n, rd_addr ? m_sig_n[63:32] : m_sig_n[31:0]);
            chk("R4 R8 swapped", rd_s, rd_addr ? m_sig_s[31:0] : m_sig_s[63:32]);
        end
    end

    task automatic drive(input logic en, input logic a, input logic [31:0] d, input logic c);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; clr = c;
    endtask

    task automatic rd_chk(input logic a, input string tag,
                          input logic [31:0] exp_n, input logic [31:0] exp_s);
        @(negedge clk);
        wr_en = 1'b0; clr = 1'b0; rd_addr = a;
        #5;
        chk(tag, rd_n, exp_n);
        chk(tag, rd_s, exp_s);
    endtask

    // Expected signatures tracked by the directed sequence
    logic [63:0] e_n, e_s;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_n = '0; e_s = '0;
        rd_chk(1'b0, "R1", 32'h0, 32'h0);
        rd_chk(1'b1, "R1", 32'h0, 32'h0);

        // R1: launch with no hold write uses a zero held half
        drive(1'b1, 1'b1, 32'h0000_0001, 1'b0);
        e_n = ref_fold(e_n, 64'h0000_0001_0000_0000);
        e_s = ref_fold(e_s, 64'h0000_0000_0000_0001);
        rd_chk(1'b0, "R3 before", 32'h0, 32'h0);
        rd_chk(1'b0, "R1 R3 after", e_n[31:0], e_s[63:32]);

        // R5: known vector on the native ordering
        drive(1'b0, 1'b0, 32'h0, 1'b1);
        drive(1'b1, 1'b0, 32'h0506_0708, 1'b0);
        drive(1'b1, 1'b1, 32'h0102_0304, 1'b0);
        e_s = ref_fold(64'h0, 64'h0506_0708_0102_0304);
        e_n = 64'h1B36_2D6C_775A_41D8;
        rd_chk(1'b0, "R3 pending", 32'h0, 32'h0);
        rd_chk(1'b0, "R5 R7 low", 32'h775A_41D8, e_s[63:32]);
        rd_chk(1'b1, "R5 R7 high", 32'h1B36_2D6C, e_s[31:0]);

        // R2: hold write leaves the signature as it was
        drive(1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0);
        rd_chk(1'b0, "R2", e_n[31:0], e_s[63:32]);
        rd_chk(1'b1, "R2", e_n[63:32], e_s[31:0]);

        // R9: last hold write wins, and the held half is reused
        drive(1'b1, 1'b0, 32'hAAAA_5555, 1'b0);
        drive(1'b1, 1'b0, 32'h1234_5678, 1'b0);
        drive(1'b1, 1'b1, 32'h9ABC_DEF0, 1'b0);
        e_n = ref_fold(e_n, 64'h9ABC_DEF0_1234_5678);
        e_s = ref_fold(e_s, 64'h1234_5678_9ABC_DEF0);
        drive(1'b0, 1'b0, 32'h0, 1'b0);
        rd_chk(1'b1, "R9 last hold", e_n[63:32], e_s[31:0]);

        // R10: launches on consecutive cycles fold two words in order
        drive(1'b1, 1'b1, 32'h0F0F_0F0F, 1'b0);
        drive(1'b1, 1'b1, 32'hF00D_CAFE, 1'b0);
        e_n = ref_fold(ref_fold(e_n, 64'h0F0F_0F0F_1234_5678), 64'hF00D_CAFE_1234_5678);
        e_s = ref_fold(ref_fold(e_s, 64'h1234_5678_0F0F_0F0F), 64'h1234_5678_F00D_CAFE);
        drive(1'b0, 1'b0, 32'h0, 1'b0);
        rd_chk(1'b0, "R9 R10 low", e_n[31:0], e_s[63:32]);
        rd_chk(1'b1, "R10 high", e_n[63:32], e_s[31:0]);

        // R6: clear lands at the same edge as a pending update
        drive(1'b1, 1'b1, 32'h7777_8888, 1'b0);
        drive(1'b0, 1'b0, 32'h0, 1'b1);
        drive(1'b0, 1'b0, 32'h0, 1'b0);
        rd_chk(1'b0, "R6 collision", 32'h0, 32'h0);
        rd_chk(1'b1, "R6 collision", 32'h0, 32'h0);

        // R9: held half survives clear, R8 known vector on the swapped ordering
        drive(1'b1, 1'b1, 32'h0506_0708, 1'b0);
        e_n = ref_fold(64'h0, 64'h0506_0708_1234_5678);
        e_s = ref_fold(64'h0, 64'h1234_5678_0506_0708);
        drive(1'b0, 1'b0, 32'h0, 1'b0);
        rd_chk(1'b1, "R9 after clear", e_n[63:32], e_s[31:0]);
        drive(1'b0, 1'b0, 32'h0, 1'b1);
        drive(1'b1, 1'b0, 32'h0102_0304, 1'b0);
        drive(1'b1, 1'b1, 32'h0506_0708, 1'b0);
        e_n = ref_fold(64'h0, 64'h0506_0708_0102_0304);
        drive(1'b0, 1'b0, 32'h0, 1'b0);
        rd_chk(1'b0, "R8 low", e_n[31:0], 32'h1B36_2D6C);
        rd_chk(1'b1, "R8 high", e_n[63:32], 32'h775A_41D8);

        // Random stream with rare clears, judged by the per-cycle model
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            wr_en   = ($urandom % 4) != 0;
            wr_addr = $urandom % 2;
            wr_data = $urandom;
            clr     = ($urandom % 16) == 0;
            rd_addr = $urandom % 2;
        end
        drive(1'b0, 1'b0, 32'h0, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule